// File: doc/BRIEF.md
# Carrier Sense and Collision Generator

This block drives the carrier sense and collision outputs of a 10/100 Ethernet PHY toward the MAC. It takes a transmit-activity flag and a receive-activity flag from the datapaths. It also takes the duplex setting, the speed setting and a heartbeat-enable setting. In half duplex, carrier follows any activity and collision flags overlapping transmit and receive. In full duplex, carrier follows receive only and collision stays low.

In 10 Mb/s half duplex with heartbeat enabled, the block also produces the signal-quality test pulse. After each transmission ends it raises collision for a fixed number of reference-clock cycles. At 25 MHz the default of 25 cycles gives about 1 µs. A parameter can delay the start of the pulse.

The activity flags arrive from other clock domains and are resynchronised. Both outputs are registered. The block runs on a single reference clock and has a synchronous reset.

Top module: `crs_col_gen`

## Requirements
- R1: With `duplex_full_i`=0 (half duplex), at either speed, `crs_o` is 1 exactly when transmit or receive activity is present.
- R2: With `duplex_full_i`=1 (full duplex), `crs_o` follows receive activity only; transmit activity alone leaves it at 0.
- R3: In half duplex, `col_o` is 1 while transmit and receive activity are present together.
- R4: With `duplex_full_i`=1, `col_o` is 0 at all times, at either speed.
- R5: In half duplex with `speed_100_i`=0 (10 Mb/s) and `hb_en_i`=1, a falling edge of transmit activity makes `col_o` high for exactly HB_CYCLES consecutive cycles (default 25). The pulse starts HB_DELAY cycles (default 0) after the synchronised edge is seen.
- R6: No heartbeat pulse is produced in full duplex, at 100 Mb/s (`speed_100_i`=1), or with `hb_en_i`=0.
- R7: If transmit activity rises again while a heartbeat pulse is pending or active, the pulse ends at once. `col_o` then follows the normal collision rule.
- R8: A change of `duplex_full_i` or `speed_100_i` cancels any heartbeat pulse in progress.
- R9: While `rst` (active high, synchronous) is 1, `crs_o` and `col_o` are 0 on the next clock and the heartbeat timer is cleared.
- R10: Each activity input passes a SYNC_STAGES-flop synchroniser (default 2), and the outputs are registered. A change of an activity input that is set up before a clock edge appears on the outputs after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_act_i | input | 1 | Transmit activity from the transmit datapath (asynchronous) |
| rx_act_i | input | 1 | Receive activity from the receive datapath (asynchronous) |
| duplex_full_i | input | 1 | 1 = full duplex, 0 = half duplex |
| speed_100_i | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| hb_en_i | input | 1 | 1 = heartbeat test pulse enabled |
| crs_o | output | 1 | Carrier sense toward the MAC |
| col_o | output | 1 | Collision toward the MAC |

## Verification
The bench builds the block with HB_CYCLES=25, SYNC_STAGES=2 and HB_DELAY=2. The non-zero delay exercises the waiting phase of the heartbeat timer, which the default value of 0 removes through generate. This opens the cases where a new transmission or a mode change arrives during the waiting phase and during the active pulse. The measured pulse width is checked against the 25-cycle length. The latency from an input change to the outputs is checked against the synchroniser depth.

// File: rtl/crs_col_pkg.sv
package crs_col_pkg;
   typedef enum logic [1:0] {
      HB_IDLE  = 2'd0,
      HB_WAIT  = 2'd1,
      HB_PULSE = 2'd2
   } hb_state_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/ccg_sync.sv
module ccg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ccg_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[0] <= 1'b0;
               else     chain[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[i] <= 1'b0;
               else     chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/ccg_edge.sv
module ccg_edge (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic rise_o,
   output logic fall_o
);
   logic d_q;

   always_ff @(posedge clk) begin
      if (rst) d_q <= 1'b0;
      else     d_q <= d_i;
   end

   assign rise_o = d_i & ~d_q;
   assign fall_o = ~d_i & d_q;
endmodule

// File: rtl/ccg_hb_timer.sv
module ccg_hb_timer
   import crs_col_pkg::*;
#(
   parameter int HB_CYCLES = 25,
   parameter int HB_DELAY  = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic start_i,
   input  logic cancel_i,
   output logic active_o
);
   localparam int CNT_MAX = max2(HB_CYCLES, HB_DELAY);
   localparam int CW      = $clog2(CNT_MAX + 1);

   hb_state_t         st;
   logic [CW-1:0]     cnt;
   hb_state_t         first_st;
   logic [CW-1:0]     first_cnt;

   generate
      if (HB_CYCLES < 1) begin : g_bad_len
         $error("ccg_hb_timer: HB_CYCLES must be at least 1");
      end
      if (HB_DELAY < 0) begin : g_bad_delay
         $error("ccg_hb_timer: HB_DELAY must not be negative");
      end
      if (HB_DELAY == 0) begin : g_direct
         assign first_st  = HB_PULSE;
         assign first_cnt = CW'(HB_CYCLES - 1);
      end else begin : g_delayed
         assign first_st  = HB_WAIT;
         assign first_cnt = CW'(HB_DELAY - 1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || cancel_i) begin
         st  <= HB_IDLE;
         cnt <= '0;
      end else if (start_i) begin
         st  <= first_st;
         cnt <= first_cnt;
      end else begin
         case (st)
            HB_WAIT: begin
               if (cnt == '0) begin
                  st  <= HB_PULSE;
                  cnt <= CW'(HB_CYCLES - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            HB_PULSE: begin
               if (cnt == '0) st <= HB_IDLE;
               else           cnt <= cnt - 1'b1;
            end
            default: begin
               st  <= HB_IDLE;
               cnt <= '0;
            end
         endcase
      end
   end

   assign active_o = (st == HB_PULSE);

   AST_HB_CANCEL: assert property (@(posedge clk) disable iff (rst)
      cancel_i |=> !active_o); // R7
   AST_HB_BOUND: assert property (@(posedge clk) disable iff (rst)
      (st == HB_PULSE) |-> (cnt <= CW'(HB_CYCLES - 1))); // R5
   AST_HB_CLEAR: assert property (@(posedge clk)
      rst |=> (st == HB_IDLE)); // R9
endmodule

// File: rtl/crs_col_gen.sv
module crs_col_gen #(
   parameter int SYNC_STAGES = 2,
   parameter int HB_CYCLES   = 25,
   parameter int HB_DELAY    = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic tx_act_i,
   input  logic rx_act_i,
   input  logic duplex_full_i,
   input  logic speed_100_i,
   input  logic hb_en_i,
   output logic crs_o,
   output logic col_o
);
   logic       tx_s, rx_s;
   logic       tx_rise, tx_fall;
   logic [1:0] mode_q;
   logic       mode_chg, hb_allowed;
   logic       hb_start, hb_cancel, hb_active;
   logic       crs_d, col_d;

   ccg_sync #(.STAGES(SYNC_STAGES)) u_sync_tx (
      .clk(clk), .rst(rst), .d_i(tx_act_i), .q_o(tx_s));
   ccg_sync #(.STAGES(SYNC_STAGES)) u_sync_rx (
      .clk(clk), .rst(rst), .d_i(rx_act_i), .q_o(rx_s));

   ccg_edge u_tx_edge (
      .clk(clk), .rst(rst), .d_i(tx_s), .rise_o(tx_rise), .fall_o(tx_fall));

   always_ff @(posedge clk) begin
      if (rst) mode_q <= 2'b00;
      else     mode_q <= {duplex_full_i, speed_100_i};
   end

   assign mode_chg   = (mode_q != {duplex_full_i, speed_100_i});
   assign hb_allowed = ~duplex_full_i & ~speed_100_i & hb_en_i;
   assign hb_start   = tx_fall & hb_allowed;
   assign hb_cancel  = tx_rise | mode_chg;

   ccg_hb_timer #(.HB_CYCLES(HB_CYCLES), .HB_DELAY(HB_DELAY)) u_hb (
      .clk(clk), .rst(rst), .start_i(hb_start), .cancel_i(hb_cancel),
      .active_o(hb_active));

   always_comb begin
      if (duplex_full_i) begin
         crs_d = rx_s;
         col_d = 1'b0;
      end else begin
         crs_d = tx_s | rx_s;
         col_d = (tx_s & rx_s) | (hb_active & ~speed_100_i);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         crs_o <= 1'b0;
         col_o <= 1'b0;
      end else begin
         crs_o <= crs_d;
         col_o <= col_d;
      end
   end

   AST_RST_QUIET: assert property (@(posedge clk)
      rst |=> (!crs_o && !col_o)); // R9
   AST_HDX_CRS: assert property (@(posedge clk) disable iff (rst)
      (!duplex_full_i && (tx_s || rx_s)) |=> crs_o); // R1
   AST_FDX_CRS: assert property (@(posedge clk) disable iff (rst)
      (duplex_full_i && !rx_s) |=> !crs_o); // R2
   AST_HDX_COL: assert property (@(posedge clk) disable iff (rst)
      (!duplex_full_i && tx_s && rx_s) |=> col_o); // R3
   AST_FDX_NO_COL: assert property (@(posedge clk) disable iff (rst)
      duplex_full_i |=> !col_o); // R4
   AST_NO_HB_FAST: assert property (@(posedge clk) disable iff (rst)
      (speed_100_i && !(tx_s && rx_s)) |=> !col_o); // R6
endmodule

// File: tb/crs_col_gen_tb.sv
module crs_col_gen_tb;
   localparam int CLK_PERIOD = 40;
   localparam int TB_SYNC    = 2;
   localparam int TB_HB_LEN  = 25;
   localparam int TB_HB_DLY  = 2;
   localparam int WATCHDOG   = 20000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tx = 1'b0, rx = 1'b0, full = 1'b0, spd = 1'b0, hben = 1'b0;
   logic crs, col;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   string tag = "R9";

   logic [1:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   crs_col_gen #(.SYNC_STAGES(TB_SYNC), .HB_CYCLES(TB_HB_LEN),
                 .HB_DELAY(TB_HB_DLY)) u_dut (
      .clk(clk), .rst(rst), .tx_act_i(tx), .rx_act_i(rx),
      .duplex_full_i(full), .speed_100_i(spd), .hb_en_i(hben),
      .crs_o(crs), .col_o(col));

   // Reference model from the requirements; predicts the outputs after each edge.
   logic m_t1, m_t2, m_r1, m_r2, m_pt;
   logic [1:0] m_pm;
   int m_phase, m_left;

   always @(posedge clk) begin
      logic ecrs, ecol, fell, rose, chg, ok;
      cycles++;
      if (rst) begin
         exp_q.push_back(2'b00);
         tag_q.push_back(tag);
         m_t1 = 0; m_t2 = 0; m_r1 = 0; m_r2 = 0; m_pt = 0;
         m_pm = 2'b00; m_phase = 0; m_left = 0;
      end else begin
         ecrs = full ? m_r2 : (m_t2 | m_r2);
         ecol = !full && ((m_t2 && m_r2) || (m_phase == 2 && !spd));
         exp_q.push_back({ecrs, ecol});
         tag_q.push_back(tag);
         fell = m_pt && !m_t2;
         rose = !m_pt && m_t2;
         chg  = ({full, spd} != m_pm);
         ok   = !full && !spd && hben;
         if (rose || chg) m_phase = 0;
         else if (fell && ok) begin
            if (TB_HB_DLY > 0) begin m_phase = 1; m_left = TB_HB_DLY - 1; end
            else begin m_phase = 2; m_left = TB_HB_LEN - 1; end
         end else if (m_phase == 1) begin
            if (m_left == 0) begin m_phase = 2; m_left = TB_HB_LEN - 1; end
            else m_left--;
         end else if (m_phase == 2) begin
            if (m_left == 0) m_phase = 0;
            else m_left--;
         end
         m_pt = m_t2; m_pm = {full, spd};
         m_t2 = m_t1; m_t1 = tx;
         m_r2 = m_r1; m_r1 = rx;
      end
   end

   // Monitor: compares every cycle away from the active edge.
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [1:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if ({crs, col} !== e) begin
            fails++;
            $display("FAIL %s crs/col actual %b%b expected %b%b", t, crs, col, e[1], e[0]);
         end
      end
   end

   task automatic drive(input logic t, input logic r, input int n, input string tg);
      @(negedge clk);
      tag = tg; tx = t; rx = r;
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic set_mode(input logic f, input logic s, input logic h);
      @(negedge clk);
      full = f; spd = s; hben = h; tx = 0; rx = 0;
      repeat (6) @(negedge clk);
   endtask

   task automatic count_col(input int n, output int hits);
      hits = 0;
      repeat (n) begin
         @(negedge clk);
         if (col) hits++;
      end
   endtask

   task automatic check_eq(input int act, input int exp, input string tg);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual %0d expected %0d", tg, act, exp);
      end
   endtask

   initial begin : watchdog
      wait (cycles > WATCHDOG);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual %0d expected <%0d cycles", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : stimulus
      int hits;
      // R9: reset state
      repeat (4) @(negedge clk);
      check_eq(int'({crs, col}), 0, "R9 outputs low in reset");
      rst = 0;
      // R1/R3 half duplex at 100 Mb/s
      set_mode(0, 1, 0);
      drive(1, 0, 8, "R1");
      drive(0, 1, 8, "R1");
      drive(1, 1, 8, "R3");
      drive(0, 0, 6, "R1");
      // R10 latency: three edges from input to output
      @(negedge clk); tag = "R10"; rx = 1;
      @(negedge clk); check_eq(crs, 0, "R10 crs after one edge");
      @(negedge clk); check_eq(crs, 0, "R10 crs after two edges");
      @(negedge clk); check_eq(crs, 1, "R10 crs after three edges");
      drive(0, 0, 6, "R10");
      // R2/R4 full duplex at both speeds
      set_mode(1, 1, 1);
      drive(1, 0, 8, "R2");
      drive(0, 1, 8, "R2");
      drive(1, 1, 8, "R4");
      set_mode(1, 0, 1);
      drive(1, 1, 8, "R4");
      drive(0, 0, 1, "R6");
      count_col(45, hits);
      check_eq(hits, 0, "R6 no pulse in 10M full duplex");
      // R5 heartbeat in 10 Mb/s half duplex
      set_mode(0, 0, 1);
      drive(1, 0, 8, "R5");
      drive(0, 0, 1, "R5");
      count_col(45, hits);
      check_eq(hits, TB_HB_LEN, "R5 pulse length");
      // R3 plus heartbeat after a collision
      drive(1, 1, 8, "R3");
      drive(0, 0, 45, "R5");
      // R6 no pulse at 100 Mb/s or with heartbeat off
      set_mode(0, 1, 1);
      drive(1, 0, 8, "R6");
      drive(0, 0, 1, "R6");
      count_col(45, hits);
      check_eq(hits, 0, "R6 no pulse at 100M");
      set_mode(0, 0, 0);
      drive(1, 0, 8, "R6");
      drive(0, 0, 1, "R6");
      count_col(45, hits);
      check_eq(hits, 0, "R6 no pulse with heartbeat off");
      // R7 restart during the pulse and during the wait phase
      set_mode(0, 0, 1);
      drive(1, 0, 8, "R7");
      drive(0, 0, 10, "R7");
      check_eq(col, 1, "R7 pulse running before restart");
      drive(1, 0, 10, "R7");
      check_eq(col, 0, "R7 pulse ended by restart");
      drive(0, 0, 3, "R7");
      drive(1, 0, 8, "R7");
      drive(0, 0, 40, "R7");
      // R8 mode change cancels the pulse
      drive(1, 0, 8, "R8");
      drive(0, 0, 10, "R8");
      @(negedge clk); tag = "R8"; spd = 1;
      repeat (4) @(negedge clk);
      count_col(30, hits);
      check_eq(hits, 0, "R8 pulse cancelled by speed change");
      set_mode(0, 0, 1);
      drive(1, 0, 8, "R8");
      drive(0, 0, 10, "R8");
      @(negedge clk); tag = "R8"; full = 1;
      count_col(30, hits);
      check_eq(hits, 0, "R8 pulse cancelled by duplex change");
      // R9 reset during a pulse
      set_mode(0, 0, 1);
      drive(1, 1, 8, "R9");
      drive(0, 0, 10, "R9");
      @(negedge clk); tag = "R9"; rst = 1;
      repeat (3) @(negedge clk);
      rst = 0;
      count_col(30, hits);
      check_eq(hits, 0, "R9 reset clears the pulse");
      repeat (4) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule